// File: doc/BRIEF.md
# Guarded Programmable Clock Divider with Shifted Companion Output

This block divides the system clock by a ratio between 1 and 32 and drives two registered outputs: the divided waveform and a companion copy. The companion copy can be turned off, inverted, or delayed by zero to three whole input clocks, and each of these settings can be changed while the divider runs. The divided output is high for the first half of each period, rounded up, so odd ratios give one extra high cycle.

Both settings are loaded through 12-bit write ports that carry a guard pattern. A write that breaks its guard still selects a defined safe setting. The write is then reported on a one-cycle error pulse. A sticky status output shows that the divider has started to toggle after reset.

Top module: `rdiv_top`

## Requirements
- R1: While reset is asserted, div_o, phase_o, running_o and bad_o are low. After reset the ratio is 16 (period 16 cycles, 8 of them high), and the companion output is enabled, not inverted and not delayed.
- R2: A ratio write of value 0xAA0 + k (k in bits 4:0, bits 11:5 equal to 0x55) selects ratio 32 when k is 0 and ratio k otherwise. The counter restarts, so div_o is high from the next cycle. For ratio N of 2 or more, div_o has period N and stays high for (N+1)/2 cycles. At ratio 1, div_o stays high.
- R3: A ratio write whose bits 11:5 are not 0x55 selects ratio 31 and raises bad_o.
- R4: A phase write with bits 11:4 equal to 0xAA loads enable from bit 3, invert from bit 2 and delay from bits 1:0. While enabled, phase_o in cycle t equals div_o in cycle t minus delay, XOR invert.
- R5: While the companion output is disabled, phase_o is low.
- R6: A phase write with any other value in bits 11:4 selects enabled, not inverted, zero delay, and raises bad_o.
- R7: At ratio 1 the invert setting has no effect on phase_o.
- R8: Selecting ratio 1 while the stored delay is non-zero raises bad_o. The delay is then treated as zero while the ratio stays 1.
- R9: running_o is low until the cycle after div_o first goes high following reset. From then on it stays high.
- R10: bad_o is a one-cycle pulse in the cycle after the offending write. Valid writes never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| div_we | input | 1 | Ratio write strobe |
| div_wdata | input | 12 | Guarded ratio code |
| ph_we | input | 1 | Phase write strobe |
| ph_wdata | input | 12 | Guard, enable, invert and delay for the companion output |
| div_o | output | 1 | Divided output |
| phase_o | output | 1 | Companion output |
| running_o | output | 1 | Divider has started since reset |
| bad_o | output | 1 | One-cycle pulse after an invalid write |

## Verification
The bench covers these cases:
- Code 0 must give 32, not 0. A divider that reads the raw code would stall or run at the wrong rate.
- The codes just past the valid window must fall back to 31 and pulse the error. Getting this wrong shows up as a wrong period or a missing pulse.
- Odd ratios must put the extra cycle in the high phase. An off-by-one split shows up as a wrong high count.
- Each delay tap is checked against a recorded history of div_o. Swapped taps or an extra pipeline stage would shift the companion output by a cycle.
- At ratio 1 with a delay still stored, a design that keeps the delay or skips the error pulse would show a companion output or pulse that does not match. So would honouring the invert setting at ratio 1.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  localparam int CODE_W = 12;
  localparam logic [CODE_W-1:0] DIV_BASE = 12'hAA0;
  localparam logic [7:0]        PH_GUARD = 8'hAA;
  localparam int RATIO_RST  = 16;
  localparam int RATIO_BAD  = 31;
  localparam int RATIO_ZERO = 32;

  typedef struct packed {
    logic       en;
    logic       inv;
    logic [1:0] shift;
  } ph_cfg_t;
endpackage

// File: rtl/rdiv_cfg.sv
module rdiv_cfg
  import rdiv_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               div_we,
  input  logic [CODE_W-1:0]  div_wdata,
  input  logic               ph_we,
  input  logic [CODE_W-1:0]  ph_wdata,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               load_o,
  output logic               en_o,
  output logic               inv_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               bad_o
);
  localparam int SEL_W = RATIO_W - 1;

  logic [RATIO_W-1:0] ratio_q, ratio_new;
  logic               div_ok, ph_ok, clash, bad_d;
  logic               en_q, inv_q, en_new, inv_new;
  logic [SHIFT_W-1:0] shift_q, shift_new, shift_next;
  logic [SEL_W-1:0]   code;

  assign code   = div_wdata[SEL_W-1:0];
  assign div_ok = (div_wdata[CODE_W-1:SEL_W] == DIV_BASE[CODE_W-1:SEL_W]);
  assign ph_ok  = (ph_wdata[CODE_W-1:4] == PH_GUARD);

  always_comb begin
    if (!div_ok)         ratio_new = RATIO_W'(RATIO_BAD);
    else if (code == '0) ratio_new = RATIO_W'(RATIO_ZERO);
    else                 ratio_new = RATIO_W'(code);
    en_new    = ph_ok ? ph_wdata[3] : 1'b1;
    inv_new   = ph_ok ? ph_wdata[2] : 1'b0;
    shift_new = ph_ok ? ph_wdata[SHIFT_W-1:0] : '0;
    shift_next = ph_we ? shift_new : shift_q;
    clash = div_we && div_ok && (ratio_new == RATIO_W'(1)) && (shift_next != '0);
    bad_d = (div_we && !div_ok) || (ph_we && !ph_ok) || clash;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RATIO_W'(RATIO_RST);
      load_o  <= 1'b0;
      en_q    <= 1'b1;
      inv_q   <= 1'b0;
      shift_q <= '0;
      bad_o   <= 1'b0;
    end else begin
      load_o <= div_we;
      bad_o  <= bad_d;
      if (div_we) ratio_q <= ratio_new;
      if (ph_we) begin
        en_q    <= en_new;
        inv_q   <= inv_new;
        shift_q <= shift_new;
      end
    end
  end

  assign ratio_o = ratio_q;
  assign en_o    = en_q;
  assign inv_o   = inv_q && (ratio_q != RATIO_W'(1));
  assign shift_o = (ratio_q == RATIO_W'(1)) ? '0 : shift_q;

  p_ratio_range_r2: assert property (@(posedge clk) disable iff (rst)
    (ratio_q != '0) && (ratio_q <= RATIO_W'(RATIO_ZERO)));
  p_bad_cause_r10: assert property (@(posedge clk) disable iff (rst)
    bad_o |-> $past(div_we || ph_we));
endmodule

// File: rtl/rdiv_count.sv
module rdiv_count #(
  parameter int RATIO_W = 6,
  parameter int CNT_W   = RATIO_W - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               load_i,
  output logic               tap0_o,
  output logic               div_o,
  output logic               running_o
);
  logic [CNT_W-1:0]   cnt, cur;
  logic [RATIO_W-1:0] hi, cur_w;
  logic               wrap;

  assign cur    = load_i ? '0 : cnt;
  assign cur_w  = RATIO_W'(cur);
  assign hi     = (ratio_i + RATIO_W'(1)) >> 1;
  assign wrap   = (cur_w == ratio_i - RATIO_W'(1));
  assign tap0_o = (cur_w < hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      div_o     <= 1'b0;
      running_o <= 1'b0;
    end else begin
      cnt   <= wrap ? '0 : cur + CNT_W'(1);
      div_o <= tap0_o;
      if (div_o) running_o <= 1'b1;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !load_i |-> (RATIO_W'(cnt) < ratio_i));
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    running_o |=> running_o);
endmodule

// File: rtl/rdiv_phase.sv
module rdiv_phase #(
  parameter int SHIFT_W = 2,
  parameter int NTAP    = 2 ** SHIFT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tap0_i,
  input  logic               div_i,
  input  logic               en_i,
  input  logic               inv_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               phase_o
);
  logic [NTAP-1:1] line;
  logic [NTAP-1:0] taps;

  assign line[1] = div_i;
  for (genvar k = 2; k < NTAP; k++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) line[k] <= 1'b0;
      else     line[k] <= line[k-1];
    end
  end

  assign taps = {line, tap0_i};

  always_ff @(posedge clk) begin
    if (rst) phase_o <= 1'b0;
    else     phase_o <= en_i ? (taps[shift_i] ^ inv_i) : 1'b0;
  end

  p_off_low_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !phase_o);
endmodule

// File: rtl/rdiv_top.sv
module rdiv_top
  import rdiv_pkg::*;
#(
  parameter int RATIO_W = 6,
  parameter int SHIFT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              div_we,
  input  logic [CODE_W-1:0] div_wdata,
  input  logic              ph_we,
  input  logic [CODE_W-1:0] ph_wdata,
  output logic              div_o,
  output logic              phase_o,
  output logic              running_o,
  output logic              bad_o
);
  logic [RATIO_W-1:0] ratio;
  logic               load, en, inv, tap0;
  logic [SHIFT_W-1:0] shift;

  rdiv_cfg #(.RATIO_W(RATIO_W), .SHIFT_W(SHIFT_W)) u_cfg (
    .clk(clk), .rst(rst), .div_we(div_we), .div_wdata(div_wdata),
    .ph_we(ph_we), .ph_wdata(ph_wdata), .ratio_o(ratio), .load_o(load),
    .en_o(en), .inv_o(inv), .shift_o(shift), .bad_o(bad_o));

  rdiv_count #(.RATIO_W(RATIO_W)) u_count (
    .clk(clk), .rst(rst), .ratio_i(ratio), .load_i(load),
    .tap0_o(tap0), .div_o(div_o), .running_o(running_o));

  rdiv_phase #(.SHIFT_W(SHIFT_W)) u_phase (
    .clk(clk), .rst(rst), .tap0_i(tap0), .div_i(div_o), .en_i(en),
    .inv_i(inv), .shift_i(shift), .phase_o(phase_o));
endmodule

// File: tb/test_rdiv_top.sv
module test_rdiv_top;
  logic clk = 1'b0, rst = 1'b1;
  logic div_we = 1'b0, ph_we = 1'b0;
  logic [11:0] div_wdata = '0, ph_wdata = '0;
  logic div_o, phase_o, running_o, bad_o;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rdiv_top i_rdiv_top (
    .clk(clk), .rst(rst), .div_we(div_we), .div_wdata(div_wdata),
    .ph_we(ph_we), .ph_wdata(ph_wdata), .div_o(div_o), .phase_o(phase_o),
    .running_o(running_o), .bad_o(bad_o));

  // {code[11:0], ratio[5:0], bad}
  localparam int NV = 9;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {12'hAA0, 6'd32, 1'b0}, {12'hAA3, 6'd3, 1'b0}, {12'hAA8, 6'd8, 1'b0},
    {12'hABF, 6'd31, 1'b0}, {12'hAC0, 6'd31, 1'b1}, {12'h123, 6'd31, 1'b1},
    {12'hAA2, 6'd2, 1'b0},  {12'hAA1, 6'd1, 1'b0},  {12'hAB0, 6'd16, 1'b0}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write strobe sits across one posedge; bad_o is sampled one negedge later
  task automatic wr_div(input logic [11:0] v, output logic b);
    @(negedge clk); div_we = 1'b1; div_wdata = v;
    @(negedge clk); div_we = 1'b0; b = bad_o;
    @(negedge clk);
    check(bad_o == 1'b0, "R10 pulse width", int'(bad_o), 0);
  endtask

  task automatic wr_ph(input logic [11:0] v, output logic b);
    @(negedge clk); ph_we = 1'b1; ph_wdata = v;
    @(negedge clk); ph_we = 1'b0; b = bad_o;
  endtask

  task automatic measure(input int n, input string req);
    int h = 0, l = 0, guard = 0;
    logic prev;
    if (n == 1) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!div_o) h++;
      end
      check(h == 0, req, h, 0);
      return;
    end
    @(negedge clk); prev = div_o;
    forever begin
      @(negedge clk); guard++;
      if ((!prev && div_o) || guard > 200) break;
      prev = div_o;
    end
    while (div_o && guard < 400) begin h++; guard++; @(negedge clk); end
    while (!div_o && guard < 400) begin l++; guard++; @(negedge clk); end
    check(h == (n + 1) / 2, {req, " high"}, h, (n + 1) / 2);
    check(h + l == n, {req, " period"}, h + l, n);
  endtask

  task automatic check_rel(input bit en, input bit inv, input int s, input string req);
    logic [3:0] hist = '0;
    int bad = 0;
    for (int i = 0; i < 44; i++) begin
      @(negedge clk);
      hist = {hist[2:0], div_o};
      if (i >= 4 && phase_o !== (en ? (hist[s] ^ inv) : 1'b0)) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic b;
    int k;
    repeat (3) @(negedge clk);
    // R1 reset values
    check({div_o, phase_o, running_o, bad_o} == 4'b0, "R1 outputs in reset",
          int'({div_o, phase_o, running_o, bad_o}), 0);
    rst = 1'b0;
    // R9 running rises one cycle after first high of div_o
    k = 0;
    do begin @(negedge clk); k++; end while (!div_o && k < 50);
    check(running_o == 1'b0, "R9 running before", int'(running_o), 0);
    @(negedge clk);
    check(running_o == 1'b1, "R9 running after", int'(running_o), 1);
    measure(16, "R1 reset ratio");
    check_rel(1'b1, 1'b0, 0, "R1 reset phase");

    // R2 R3 R10 table walk
    for (int v = 0; v < NV; v++) begin
      wr_div(VEC[v][18:7], b);
      check(b == VEC[v][0], "R3/R10 error pulse", int'(b), int'(VEC[v][0]));
      measure(int'(VEC[v][6:1]), "R2 ratio");
    end
    check(running_o == 1'b1, "R9 sticky", int'(running_o), 1);

    // R4 R5 R6 phase settings at ratio 8
    wr_div(12'hAA8, b);
    wr_ph(12'hAA8, b);
    check(b == 1'b0, "R10 valid phase write", int'(b), 0);
    check_rel(1'b1, 1'b0, 0, "R4 shift0");
    wr_ph(12'hAAE, b); check_rel(1'b1, 1'b1, 2, "R4 invert shift2");
    wr_ph(12'hAAF, b); check_rel(1'b1, 1'b1, 3, "R4 invert shift3");
    wr_ph(12'hAA9, b); check_rel(1'b1, 1'b0, 1, "R4 shift1");
    wr_ph(12'hAA0, b); check_rel(1'b0, 1'b0, 0, "R5 disabled");
    wr_ph(12'h12F, b);
    check(b == 1'b1, "R6 guard error", int'(b), 1);
    check_rel(1'b1, 1'b0, 0, "R6 fallback");
    wr_div(12'hAA5, b);
    wr_ph(12'hAAD, b); check_rel(1'b1, 1'b1, 1, "R4 odd ratio");

    // R8 ratio 1 with stored delay
    wr_ph(12'hAAB, b);
    wr_div(12'hAA1, b);
    check(b == 1'b1, "R8 clash error", int'(b), 1);
    check_rel(1'b1, 1'b0, 0, "R8 delay forced zero");
    // R7 invert ignored at ratio 1
    wr_ph(12'hAAC, b);
    check(b == 1'b0, "R7 no error", int'(b), 0);
    check_rel(1'b1, 1'b0, 0, "R7 invert ignored");
    check(phase_o == 1'b1, "R7 phase high", int'(phase_o), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule